// File: doc/BRIEF.md
# YCrCb to RGB Pixel Converter

This block turns a stream of luma/chroma pixels into red, green and blue components for a display path. Each cycle in which `in_valid` is high, one Y, Cr, Cb triple is captured; three register stages later the matching RGB triple appears on the outputs together with `out_valid`. The stream can have gaps of any length, and each valid pixel is handled on its own.

All arithmetic is integer. Every constant coefficient is held as its real value times 2048. Each of the five coefficient products is read from a constant table that is computed at elaboration and indexed directly by the raw component code. The table holds the product with the video offset already removed. A later stage adds the products, shifts away the scaling and saturates each channel to the component range. The component width parameter sets both the table depth and the luma and chroma offsets.

Top module: `ycc2rgb_conv`

## Requirements
- R1: Parameter `CW` selects 8-bit or 10-bit components. The luma offset is 16 when `CW`=8 and 64 when `CW`=10. The chroma offset is 128 when `CW`=8 and 512 when `CW`=10. In 8-bit mode Y=16 with neutral chroma gives 0 on all channels, and Y=235 with neutral chroma gives 254 on all channels.
- R2: Red is the saturation of (2384·(Y−Yoff) + 3269·(Cr−Coff)) shifted arithmetically right by 11 bits. The shift rounds toward minus infinity.
- R3: Green is the saturation of (2384·(Y−Yoff) − 1665·(Cr−Coff) − 803·(Cb−Coff)) shifted arithmetically right by 11 bits.
- R4: Blue is the saturation of (2384·(Y−Yoff) + 4131·(Cb−Coff)) shifted arithmetically right by 11 bits.
- R5: A channel whose scaled sum is negative is output as 0.
- R6: A channel whose shifted sum is greater than 2^CW−1 is output as 2^CW−1.
- R7: A pixel captured at rising edge n is on the outputs right after edge n+2, with `out_valid` high. `out_valid` is high exactly when `in_valid` was high at the edge three edges before the sampling edge.
- R8: While `out_valid` is low, `out_r`, `out_g` and `out_b` keep the values of the last valid pixel. Inputs presented with `in_valid` low have no effect.
- R9: `rst_n` low clears every pipeline valid bit at once, so `out_valid` is 0 during reset. A pixel that was in flight when reset was asserted never appears.
- R10: A pixel with Cr and Cb both equal to the chroma offset gives equal R, G and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously to `clk` |
| in_valid | input | 1 | Input triple is valid this cycle |
| in_y | input | CW | Luma code |
| in_cr | input | CW | Red-difference chroma code |
| in_cb | input | CW | Blue-difference chroma code |
| out_valid | output | 1 | Output triple is valid |
| out_r | output | CW | Red component |
| out_g | output | CW | Green component |
| out_b | output | CW | Blue component |

## Verification
A wrong entry in a product table, or a wrong offset, shows on one or more channels three edges after the first pixel whose code indexes that entry. The bench therefore sweeps every luma code and many random chroma codes. A valid bit that is lost or duplicated shows on `out_valid` within the same three edges. A data register that loads while its stage is idle changes the held outputs during the next gap in the stream. The bench compares all four outputs against a behavioural model after every clock, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  // fixed-point fraction bits of all coefficients
  localparam int FRAC = 11;
  // coefficients as real value times 2^FRAC
  localparam int K_Y   = 2384;
  localparam int K_RCR = 3269;
  localparam int K_GCR = 1665;
  localparam int K_GCB = 803;
  localparam int K_BCB = 4131;
  localparam int N_TAB = 5;
  localparam int N_CH  = 3;

  function automatic int luma_off(input int cw);
    return 1 << (cw - 4);
  endfunction

  function automatic int chroma_off(input int cw);
    return 1 << (cw - 1);
  endfunction

  // signed width of one table product: |coef| < 2^13, |diff| <= 2^CW
  function automatic int prod_w(input int cw);
    return cw + 14;
  endfunction
endpackage

// File: rtl/ycc_lut_mul.sv
module ycc_lut_mul #(
  parameter int CW   = 8,
  parameter int COEF = 0,
  parameter int OFF  = 0,
  parameter int PW   = 22
) (
  input  logic                 clk,
  input  logic                 ld_en,
  input  logic [CW-1:0]        idx,
  output logic signed [PW-1:0] prod
);
  localparam int DEPTH = 1 << CW;

  logic signed [PW-1:0] rom [DEPTH];
  logic signed [PW-1:0] prod_d;
  logic signed [PW-1:0] prod_q;

  // constant table: entry i holds COEF * (i - OFF)
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int ENTRY = COEF * (i - OFF);
    assign rom[i] = PW'(ENTRY);
  end

  always_comb begin
    prod_d = prod_q;
    if (ld_en) begin
      prod_d = rom[idx];
    end
  end

  always_ff @(posedge clk) begin
    prod_q <= prod_d;
  end

  assign prod = prod_q;
endmodule

// File: rtl/ycc_mix.sv
module ycc_mix #(
  parameter int PW = 22,
  parameter int SW = 24
) (
  input  logic                 clk,
  input  logic                 ld_en,
  input  logic signed [PW-1:0] t_y,
  input  logic signed [PW-1:0] t_rcr,
  input  logic signed [PW-1:0] t_gcr,
  input  logic signed [PW-1:0] t_gcb,
  input  logic signed [PW-1:0] t_bcb,
  output logic signed [SW-1:0] s_r,
  output logic signed [SW-1:0] s_g,
  output logic signed [SW-1:0] s_b
);
  logic signed [SW-1:0] e_y, e_rcr, e_gcr, e_gcb, e_bcb;
  logic signed [SW-1:0] r_d, g_d, b_d;
  logic signed [SW-1:0] r_q, g_q, b_q;

  // sign extension to the sum width
  assign e_y   = SW'(t_y);
  assign e_rcr = SW'(t_rcr);
  assign e_gcr = SW'(t_gcr);
  assign e_gcb = SW'(t_gcb);
  assign e_bcb = SW'(t_bcb);

  always_comb begin
    r_d = r_q;
    g_d = g_q;
    b_d = b_q;
    if (ld_en) begin
      r_d = e_y + e_rcr;
      g_d = e_y - e_gcr - e_gcb;
      b_d = e_y + e_bcb;
    end
  end

  always_ff @(posedge clk) begin
    r_q <= r_d;
    g_q <= g_d;
    b_q <= b_d;
  end

  assign s_r = r_q;
  assign s_g = g_q;
  assign s_b = b_q;
endmodule

// File: rtl/ycc_clamp.sv
module ycc_clamp #(
  parameter int CW   = 8,
  parameter int SW   = 24,
  parameter int FRAC = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic signed [SW-1:0] sum,
  output logic [CW-1:0]        chan
);
  localparam logic signed [SW-1:0] TOP    = SW'((1 << CW) - 1);
  localparam logic signed [SW-1:0] SAT_AT = SW'(1 << (CW + FRAC));

  logic signed [SW-1:0] scaled;
  logic [CW-1:0]        chan_d;
  logic [CW-1:0]        chan_q;

  assign scaled = sum >>> FRAC;

  always_comb begin
    chan_d = chan_q;
    if (ld_en) begin
      if (scaled[SW-1]) begin
        chan_d = '0;
      end else if (scaled > TOP) begin
        chan_d = '1;
      end else begin
        chan_d = scaled[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    chan_q <= chan_d;
  end

  assign chan = chan_q;

  // R5
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && sum[SW-1]) |=> (chan_q == '0));

  // R6
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && (sum >= SAT_AT)) |=> (chan_q == {CW{1'b1}}));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(chan_q));
endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
  import ycc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_cr,
  input  logic [CW-1:0] in_cb,
  output logic          out_valid,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  localparam int YOFF   = luma_off(CW);
  localparam int COFF   = chroma_off(CW);
  localparam int PW     = prod_w(CW);
  localparam int SW     = PW + 2;
  localparam int STAGES = 3;

  logic [STAGES-1:0]    vld_d;
  logic [STAGES-1:0]    vld_q;
  logic signed [PW-1:0] term [N_TAB];
  logic signed [SW-1:0] sums [N_CH];
  logic [CW-1:0]        chan [N_CH];

  // valid pipeline, one bit per register stage
  always_comb begin
    vld_d = {vld_q[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // stage 1: constant product tables (0:Y 1:Cr->R 2:Cr->G 3:Cb->G 4:Cb->B)
  for (genvar t = 0; t < N_TAB; t++) begin : g_tab
    localparam int KC = (t == 0) ? K_Y   :
                        (t == 1) ? K_RCR :
                        (t == 2) ? K_GCR :
                        (t == 3) ? K_GCB : K_BCB;
    localparam int KO = (t == 0) ? YOFF : COFF;
    logic [CW-1:0] sel;
    if (t == 0) begin : g_y
      assign sel = in_y;
    end else if (t < 3) begin : g_cr
      assign sel = in_cr;
    end else begin : g_cb
      assign sel = in_cb;
    end
    ycc_lut_mul #(
      .CW  (CW),
      .COEF(KC),
      .OFF (KO),
      .PW  (PW)
    ) u_tab (
      .clk  (clk),
      .ld_en(in_valid),
      .idx  (sel),
      .prod (term[t])
    );
  end

  // stage 2: channel sums
  ycc_mix #(
    .PW(PW),
    .SW(SW)
  ) u_mix (
    .clk  (clk),
    .ld_en(vld_q[0]),
    .t_y  (term[0]),
    .t_rcr(term[1]),
    .t_gcr(term[2]),
    .t_gcb(term[3]),
    .t_bcb(term[4]),
    .s_r  (sums[0]),
    .s_g  (sums[1]),
    .s_b  (sums[2])
  );

  // stage 3: descale and saturate each channel
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ycc_clamp #(
      .CW  (CW),
      .SW  (SW),
      .FRAC(FRAC)
    ) u_clamp (
      .clk  (clk),
      .rst_n(rst_n),
      .ld_en(vld_q[1]),
      .sum  (sums[c]),
      .chan (chan[c])
    );
  end

  assign out_valid = vld_q[STAGES-1];
  assign out_r     = chan[0];
  assign out_g     = chan[1];
  assign out_b     = chan[2];

  // R7
  lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R10
  gray_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cr == CW'(COFF) && in_cb == CW'(COFF))
      |-> ##3 (out_r == out_g && out_g == out_b));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_clear_chk: assert (!out_valid);
    end
  end
endmodule

// File: tb/ycc2rgb_conv_tb.sv
`timescale 1ns/1ps
module ycc2rgb_conv_tb_top;
  localparam int CW = 8;
  localparam int YO = 16;
  localparam int CO = 128;
  localparam int MX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_y = '0;
  logic [CW-1:0] in_cr = '0;
  logic [CW-1:0] in_cb = '0;
  logic          out_valid;
  logic [CW-1:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model: history of captured pixels, newest at index 0
  bit hv [3];
  int hy [3];
  int hcr [3];
  int hcb [3];
  bit have = 1'b0;
  int er, eg, eb;

  always #2.5 clk = ~clk;

  ycc2rgb_conv #(.CW(CW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_y     (in_y),
    .in_cr    (in_cr),
    .in_cb    (in_cb),
    .out_valid(out_valid),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b)
  );

  function automatic int sat(input int x);
    int s;
    s = x >>> 11;
    if (s < 0) return 0;
    if (s > MX) return MX;
    return s;
  endfunction

  function automatic int ref_r(input int y, input int cr);
    return sat(2384 * (y - YO) + 3269 * (cr - CO));
  endfunction

  function automatic int ref_g(input int y, input int cr, input int cb);
    return sat(2384 * (y - YO) - 1665 * (cr - CO) - 803 * (cb - CO));
  endfunction

  function automatic int ref_b(input int y, input int cb);
    return sat(2384 * (y - YO) + 4131 * (cb - CO));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, advance the model at the edge, compare at the next falling edge
  task automatic step(input bit v, input int y, input int cr, input int cb, input string tag);
    in_valid = v;
    in_y     = CW'(y);
    in_cr    = CW'(cr);
    in_cb    = CW'(cb);
    @(posedge clk);
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hy[k] = hy[k-1]; hcr[k] = hcr[k-1]; hcb[k] = hcb[k-1];
    end
    hv[0] = v; hy[0] = y; hcr[0] = cr; hcb[0] = cb;
    if (hv[2]) begin
      have = 1'b1;
      er = ref_r(hy[2], hcr[2]);
      eg = ref_g(hy[2], hcr[2], hcb[2]);
      eb = ref_b(hy[2], hcb[2]);
    end
    @(negedge clk);
    chk("R7 out_valid", int'(out_valid), int'(hv[2]));
    if (have) begin
      chk({tag, " red"}, int'(out_r), er);
      chk({tag, " green"}, int'(out_g), eg);
      chk({tag, " blue"}, int'(out_b), eb);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) hv[k] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1;
    do_reset();
    step(1'b0, 0, 0, 0, "R9 after reset");

    // R1: offset-dependent fixed points
    step(1'b1, 16, 128, 128, "R1 black");
    step(1'b1, 235, 128, 128, "R1 white");
    step(1'b0, 0, 0, 0, "R1");
    step(1'b0, 0, 0, 0, "R1");
    chk("R1 white red", int'(out_r), 254);

    // R10: full luma sweep with neutral chroma
    for (int y = 0; y <= MX; y++) begin
      step(1'b1, y, CO, CO, "R10 gray");
    end

    // R5 / R6: extremes saturate low and high
    step(1'b1, 0, 0, 0, "R5 low corner");
    step(1'b1, MX, MX, MX, "R6 high corner");
    step(1'b1, 0, MX, 0, "R5/R6 mixed");
    step(1'b1, MX, 0, MX, "R5/R6 mixed");
    step(1'b0, 0, 0, 0, "R5");
    step(1'b0, 0, 0, 0, "R6");

    // R2 / R3 / R4: random pixels back to back
    for (int n = 0; n < 400; n++) begin
      step(1'b1, int'($urandom_range(0, MX)), int'($urandom_range(0, MX)),
           int'($urandom_range(0, MX)), "R2/R3/R4 stream");
    end

    // R8: gaps carrying junk inputs, R7 bubbles
    for (int n = 0; n < 300; n++) begin
      step(($urandom_range(0, 2) == 0), int'($urandom_range(0, MX)),
           int'($urandom_range(0, MX)), int'($urandom_range(0, MX)), "R8 gaps");
    end
    for (int n = 0; n < 8; n++) begin
      step(1'b0, int'($urandom_range(0, MX)), int'($urandom_range(0, MX)),
           int'($urandom_range(0, MX)), "R8 idle");
    end

    // R9: reset with pixels in flight
    step(1'b1, 100, 200, 50, "R9 pre");
    step(1'b1, 180, 40, 220, "R9 pre");
    do_reset();
    for (int n = 0; n < 4; n++) begin
      step(1'b0, 0, 0, 0, "R9 flushed");
    end
    step(1'b1, 81, 90, 240, "R2/R3/R4 after reset");
    for (int n = 0; n < 4; n++) begin
      step(1'b0, 0, 0, 0, "R8 after reset");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule